// File: doc/BRIEF.md
# Multi-Source Reset Pulse Generator

This block merges three independent reset causes into one system reset. The causes are a supply-fault level from an external comparator, a single-cycle watchdog expiry pulse and a debounced pushbutton-held level. While any cause is present, reset is driven. Once every cause has gone away, reset is held for a fixed number of millisecond ticks before it is released.

A free-running 1 ms tick, one clock wide, paces the hold timer. A cause that appears during the hold window restarts the full window. Reset is driven on two registered pins, one active high and one active low, which are always exact complements. The supply threshold select is a configuration bit that the block only registers and passes on. The block puts reset out from power-on through its asynchronous reset input.

There is no data stream, so every pin is a plain control level or pulse and there is no valid/ready handshake.

Top module: `rst_pulse_gen`

## Requirements
- R1: If any cause (`supply_fault`, `wdt_expired` or `button_held`) is high at a rising clock edge, `sys_rst` is 1 after that edge.
- R2: After `supply_fault` clears, `sys_rst` stays 1 until the edge that samples the HOLD_MS-th tick with no cause present, and goes to 0 at that edge.
- R3: After a one-cycle `wdt_expired` pulse, `sys_rst` is held for exactly HOLD_MS ticks, counted as in R2.
- R4: After `button_held` is released, `sys_rst` is held for exactly HOLD_MS ticks, counted as in R2.
- R5: A cause seen during the hold window restarts the count from HOLD_MS. A tick sampled while a cause is present does not count.
- R6: `sys_rst_n` equals the inverse of `sys_rst` at all times, including during reset.
- R7: While `rst_n` is 0, `sys_rst` is 1. After `rst_n` is released, `sys_rst` stays 1 for HOLD_MS ticks even if no cause is present.
- R8: `thr_sel_o` equals the value `thr_sel_i` had at the previous rising edge, and is 0 while `rst_n` is 0.
- R9: `sys_rst` goes from 1 to 0 only at an edge that samples `tick_ms` = 1 with no cause present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| supply_fault | input | 1 | Supply below threshold, level, active high |
| wdt_expired | input | 1 | Watchdog timeout, one-cycle pulse |
| button_held | input | 1 | Debounced pushbutton request, level, active high |
| thr_sel_i | input | 1 | Supply threshold select configuration bit |
| thr_sel_o | output | 1 | Registered copy of thr_sel_i |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The main function is tried with each cause on its own: a long supply-fault level, a single watchdog pulse and a button hold. Each of these must give the same hold length, which shows that level causes and pulse causes reach the same timer. A sequence that chains causes inside one hold window shows whether the counter reloads or just carries on; it must produce a single release. An asynchronous reset in the middle of a hold shows that power-on restarts the full window. The threshold bit is toggled throughout so that its one-cycle delay is checked separately from the reset path.

// File: rtl/rpg_pkg.sv
package rpg_pkg;
  typedef struct packed {
    logic supply;
    logic wdt;
    logic button;
  } cause_t;

  function automatic logic cause_any(input cause_t c);
    return c.supply | c.wdt | c.button;
  endfunction
endpackage

// File: rtl/rpg_cause_merge.sv
module rpg_cause_merge
  import rpg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  cause_t causes,
  input  logic   thr_in,
  output logic   any_active,
  output logic   thr_out
);
  assign any_active = cause_any(causes);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_out <= 1'b0;
    else        thr_out <= thr_in;
  end
endmodule

// File: rtl/rpg_hold_timer.sv
module rpg_hold_timer #(
  parameter int HOLD_MS = 250,
  parameter int CNT_W   = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_active,
  input  logic tick,
  output logic hold_on
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLD_MS);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (any_active)                 cnt_d = LOAD;
    else if (tick && cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else                            cnt_d = cnt_q;
  end

  // next-state view: reset may drop on the same edge the count hits zero
  assign hold_on = (cnt_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= LOAD;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rpg_out_drv.sv
module rpg_out_drv (
  input  logic clk,
  input  logic rst_n,
  input  logic assert_rst,
  output logic rst_hi,
  output logic rst_lo
);
  localparam int NPOL = 2;
  // index 0: active-high pin, index 1: active-low pin
  localparam logic [NPOL-1:0] INV = 2'b10;

  logic [NPOL-1:0] pin_q;

  genvar g;
  generate
    for (g = 0; g < NPOL; g++) begin : g_pol
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q[g] <= ~INV[g];
        else        pin_q[g] <= assert_rst ^ INV[g];
      end
    end
  endgenerate

  assign rst_hi = pin_q[0];
  assign rst_lo = pin_q[1];
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int HOLD_MS  = 250,
  parameter int HOLD_MAX = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_ms,
  input  logic supply_fault,
  input  logic wdt_expired,
  input  logic button_held,
  input  logic thr_sel_i,
  output logic thr_sel_o,
  output logic sys_rst,
  output logic sys_rst_n
);
  import rpg_pkg::*;

  localparam int CNT_W = $clog2(HOLD_MAX + 1);

  cause_t causes;
  logic   any_active;
  logic   hold_on;

  assign causes = '{supply: supply_fault, wdt: wdt_expired, button: button_held};

  rpg_cause_merge u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .causes     (causes),
    .thr_in     (thr_sel_i),
    .any_active (any_active),
    .thr_out    (thr_sel_o)
  );

  rpg_hold_timer #(.HOLD_MS(HOLD_MS), .CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .any_active (any_active),
    .tick       (tick_ms),
    .hold_on    (hold_on)
  );

  rpg_out_drv u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .assert_rst (any_active | hold_on),
    .rst_hi     (sys_rst),
    .rst_lo     (sys_rst_n)
  );
endmodule

// File: rtl/rst_pulse_gen_chk.sv
module rst_pulse_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_ms,
  input logic supply_fault,
  input logic wdt_expired,
  input logic button_held,
  input logic thr_sel_i,
  input logic thr_sel_o,
  input logic sys_rst,
  input logic sys_rst_n
);
  logic cause;
  assign cause = supply_fault | wdt_expired | button_held;

  p_cause_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> sys_rst);

  p_complement_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst == !sys_rst_n);

  p_release_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst && !(tick_ms && !cause) |=> sys_rst);

  p_thr_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> thr_sel_o == $past(thr_sel_i));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cause |=> ##1 sys_rst);
endmodule

bind rst_pulse_gen rst_pulse_gen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .tick_ms      (tick_ms),
  .supply_fault (supply_fault),
  .wdt_expired  (wdt_expired),
  .button_held  (button_held),
  .thr_sel_i    (thr_sel_i),
  .thr_sel_o    (thr_sel_o),
  .sys_rst      (sys_rst),
  .sys_rst_n    (sys_rst_n)
);

// File: tb/rst_pulse_gen_bench.sv
module rst_pulse_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 6;
  localparam int TICK_DIV   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic supply_fault = 1'b0;
  logic wdt_expired = 1'b0;
  logic button_held = 1'b0;
  logic thr_sel_i = 1'b0;
  logic thr_sel_o, sys_rst, sys_rst_n;

  int vectors = 0;
  int miscompares = 0;
  int exp_q[$];
  string tag = "R7";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_pulse_gen #(.HOLD_MS(HOLD), .HOLD_MAX(1000)) u_rst_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
    .supply_fault(supply_fault), .wdt_expired(wdt_expired),
    .button_held(button_held), .thr_sel_i(thr_sel_i),
    .thr_sel_o(thr_sel_o), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // tick generator, driven just after the edge
  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV; i++) begin
        @(posedge clk); #1;
        tick_ms = (i == TICK_DIV - 1);
      end
    end
  end

  // monitor: reference count of qualifying ticks since the last cause
  int  ticks = 0;
  bit  pv = 1'b0, p_cause = 1'b0, p_tick = 1'b0, p_thr = 1'b0, p_rst = 1'b1;
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R7", sys_rst, 1);
      check("R6", sys_rst_n, 0);
      check("R8", thr_sel_o, 0);
      ticks = 0;
      pv = 1'b0;
    end else begin
      if (pv) begin
        if (p_cause) ticks = 0;
        else if (p_tick && ticks < HOLD) ticks++;
        check(tag, sys_rst, (ticks < HOLD) ? 1 : 0);
        check("R8", thr_sel_o, p_thr);
      end else begin
        check("R7", sys_rst, 1);
      end
      check("R6", sys_rst_n, !sys_rst);
      if (p_rst && !sys_rst) begin
        if (exp_q.size() == 0) check({tag, " unexpected release"}, 1, 0);
        else check({tag, " hold ticks"}, ticks, exp_q.pop_front());
      end
      p_cause = supply_fault | wdt_expired | button_held;
      p_tick  = tick_ms;
      p_thr   = thr_sel_i;
      pv      = 1'b1;
    end
    p_rst = sys_rst;
  end

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; thr_sel_i = ~thr_sel_i; end
  endtask

  task automatic wait_release();
    int guard = 0;
    while (sys_rst !== 1'b0 && guard < 500) begin @(negedge clk); guard++; end
    if (guard >= 500) check({tag, " release timeout"}, 0, 1);
    cyc(3);
  endtask

  initial begin
    cyc(4);
    tag = "R7";
    exp_q.push_back(HOLD);
    @(posedge clk); #1; rst_n = 1'b1;
    wait_release();

    tag = "R2"; exp_q.push_back(HOLD);
    supply_fault = 1'b1; cyc(10); supply_fault = 1'b0;
    wait_release();

    tag = "R3"; exp_q.push_back(HOLD);
    wdt_expired = 1'b1; cyc(1); wdt_expired = 1'b0;
    wait_release();

    tag = "R4"; exp_q.push_back(HOLD);
    button_held = 1'b1; cyc(8); button_held = 1'b0;
    wait_release();

    // R5: causes chained inside one window give a single release
    tag = "R5"; exp_q.push_back(HOLD);
    button_held = 1'b1; cyc(4); button_held = 1'b0;
    cyc(8);
    supply_fault = 1'b1; cyc(7); supply_fault = 1'b0;
    cyc(10);
    wdt_expired = 1'b1; cyc(1); wdt_expired = 1'b0;
    wait_release();

    // R7: asynchronous reset in the middle of a hold window
    tag = "R7"; exp_q.push_back(HOLD);
    button_held = 1'b1; cyc(3); button_held = 1'b0; cyc(5);
    #2 rst_n = 1'b0; cyc(3);
    @(posedge clk); #1; rst_n = 1'b1;
    wait_release();

    // R9: pulse landing on a tick cycle
    tag = "R9"; exp_q.push_back(HOLD);
    while (tick_ms !== 1'b1) @(negedge clk);
    wdt_expired = 1'b1; cyc(1); wdt_expired = 1'b0;
    wait_release();

    check("R5 queue drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule